// File: doc/BRIEF.md
# DMA Channel Pointer and Byte-Count Unit

This block keeps the source pointer, the destination pointer and the remaining byte count of one DMA channel. Software loads the three values through a simple write port while the channel is idle. A start strobe then checks them against the configured source and destination port sizes. A clean set launches the channel. A bad set raises a sticky configuration fault, and the channel stays idle.

While the channel runs, each transfer-done strobe marks the end of one operand transfer. On that strobe each pointer whose increment is enabled advances by its own side's operand size. The count drops by the wider of the two operand sizes. When the count is used up, the channel stops and raises its terminal-count flag. Bus sequencing and request handling sit outside this block.

Top module: `dma_ptr_unit`

## Requirements
- R1: After reset both pointers and the count are zero, and `active`, `tc` and `cfg_err` are low.
- R2: While idle, a write with `wr_sel` 00 loads the source pointer, 01 loads the destination pointer, 10 loads the count, and 11 loads nothing. The new value shows one cycle later. While `active` is high, writes have no effect.
- R3: Size codes are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes, and 11 is invalid. A start raises `cfg_err` and leaves the channel idle in two cases: a pointer is not a multiple of its own side's size, or either size code is 11.
- R4: A start raises `cfg_err` when the count is not a multiple of the larger of the two sizes.
- R5: A start raises `cfg_err` when the count is zero.
- R6: On each transfer-done while active, the source pointer grows by the source size if `src_inc` is set. If `src_inc` is clear, the source pointer does not change.
- R7: On each transfer-done while active, the destination pointer grows by the destination size, not the source size, if `dst_inc` is set. If `dst_inc` is clear, it does not change.
- R8: On each transfer-done while active, the count drops by the larger size. If the count is no more than that step, the count becomes zero, `tc` goes high and `active` goes low.
- R9: `cfg_err` stays high until an `err_clr` pulse. A start while it is held is ignored. When `err_clr` and `start` come in the same cycle, the clear takes effect first and the start is then checked normally.
- R10: A transfer-done while idle changes nothing.
- R11: A start that passes the checks sets `active` and clears `tc` on the next edge. The checks use the register values from before any write in the same cycle. A start while active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 source, 01 destination, 10 count |
| wr_data | input | AW | Write data |
| src_size | input | 2 | Source operand size code |
| dst_size | input | 2 | Destination operand size code |
| src_inc | input | 1 | Source pointer increment enable |
| dst_inc | input | 1 | Destination pointer increment enable |
| start | input | 1 | Channel start strobe |
| xfer_done | input | 1 | One operand transfer completed |
| err_clr | input | 1 | Clears the configuration fault |
| src_addr | output | AW | Current source pointer |
| dst_addr | output | AW | Current destination pointer |
| byte_cnt | output | CW | Remaining byte count |
| active | output | 1 | Channel running |
| tc | output | 1 | Terminal count reached |
| cfg_err | output | 1 | Latched configuration fault |

## Verification
Two functions meet in the same cycle: the fault clear and the start check. A start arriving together with `err_clr` must be judged on its own merits, not blocked by the fault that is being cleared. Directed cases drive this pairing with both clean and bad register sets. The random phase also lets the two strobes land together freely. A reference model in the bench applies the clear before the start decision, and every output is compared with it after each edge.

// File: rtl/dma_ptr_pkg.sv
package dma_ptr_pkg;

   typedef enum logic [1:0] {
      PSZ_QUAD = 2'b00,
      PSZ_ONE  = 2'b01,
      PSZ_PAIR = 2'b10,
      PSZ_BAD  = 2'b11
   } psize_e;

   localparam logic [1:0] SEL_SRC = 2'b00;
   localparam logic [1:0] SEL_DST = 2'b01;
   localparam logic [1:0] SEL_CNT = 2'b10;

   // operand size in bytes; the invalid code yields zero
   function automatic logic [2:0] psize_bytes(input logic [1:0] code);
      case (psize_e'(code))
         PSZ_QUAD: psize_bytes = 3'd4;
         PSZ_ONE:  psize_bytes = 3'd1;
         PSZ_PAIR: psize_bytes = 3'd2;
         default:  psize_bytes = 3'd0;
      endcase
   endfunction

   // low address bits that must be zero for a given size
   function automatic logic [1:0] psize_mask(input logic [1:0] code);
      case (psize_e'(code))
         PSZ_QUAD: psize_mask = 2'b11;
         PSZ_PAIR: psize_mask = 2'b01;
         default:  psize_mask = 2'b00;
      endcase
   endfunction

   function automatic logic [1:0] psize_wider(input logic [1:0] a, input logic [1:0] b);
      psize_wider = (psize_bytes(a) >= psize_bytes(b)) ? a : b;
   endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
   import dma_ptr_pkg::*;
(
   input  logic [1:0] src_lo,
   input  logic [1:0] dst_lo,
   input  logic [1:0] cnt_lo,
   input  logic       cnt_zero,
   input  logic [1:0] src_size,
   input  logic [1:0] dst_size,
   output logic       cfg_ok
);
   logic size_bad, src_mis, dst_mis, cnt_mis;
   logic [1:0] wide;

   always_comb begin
      wide     = psize_wider(src_size, dst_size);
      size_bad = (src_size == PSZ_BAD) || (dst_size == PSZ_BAD);
      src_mis  = |(src_lo & psize_mask(src_size));
      dst_mis  = |(dst_lo & psize_mask(dst_size));
      cnt_mis  = |(cnt_lo & psize_mask(wide));
      cfg_ok   = !(size_bad || src_mis || dst_mis || cnt_mis || cnt_zero);
   end
endmodule

// File: rtl/dma_ptr_step.sv
module dma_ptr_step #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step_en,
   input  logic [2:0]    step_bytes,
   output logic [AW-1:0] addr
);
   logic [AW-1:0] addr_q;
   logic [AW-1:0] inc_ext;

   assign inc_ext = {{(AW-3){1'b0}}, step_bytes};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (load)    addr_q <= load_val;
      else if (step_en) addr_q <= addr_q + inc_ext;
   end

   assign addr = addr_q;
endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec_en,
   input  logic [2:0]    dec_bytes,
   output logic [CW-1:0] cnt,
   output logic          last
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] dec_ext;

   assign dec_ext = {{(CW-3){1'b0}}, dec_bytes};
   assign last    = (cnt_q <= dec_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load)   cnt_q <= load_val;
      else if (dec_en) cnt_q <= last ? '0 : cnt_q - dec_ext;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit
   import dma_ptr_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [AW-1:0] wr_data,
   input  logic [1:0]    src_size,
   input  logic [1:0]    dst_size,
   input  logic          src_inc,
   input  logic          dst_inc,
   input  logic          start,
   input  logic          xfer_done,
   input  logic          err_clr,
   output logic [AW-1:0] src_addr,
   output logic [AW-1:0] dst_addr,
   output logic [CW-1:0] byte_cnt,
   output logic          active,
   output logic          tc,
   output logic          cfg_err
);
   localparam int NPTR = 2;

   if (AW < 4) begin : g_aw_chk
      $error("dma_ptr_unit: AW must be at least 4");
   end
   if (CW < 4 || CW > AW) begin : g_cw_chk
      $error("dma_ptr_unit: CW must lie in 4..AW");
   end

   logic active_q, tc_q, err_q;
   logic wr_ok, err_held, start_try, cfg_ok, launch, fault, step, cnt_last;
   logic [1:0]    wide_size;
   logic [2:0]    wide_bytes;
   logic [1:0]    size_v [NPTR];
   logic          inc_v  [NPTR];
   logic [AW-1:0] ptr_v  [NPTR];

   assign size_v[0] = src_size;
   assign size_v[1] = dst_size;
   assign inc_v[0]  = src_inc;
   assign inc_v[1]  = dst_inc;

   assign wr_ok      = wr_en && !active_q;
   assign err_held   = err_q && !err_clr;
   assign start_try  = start && !active_q && !err_held;
   assign launch     = start_try && cfg_ok;
   assign fault      = start_try && !cfg_ok;
   assign step       = xfer_done && active_q;
   assign wide_size  = psize_wider(src_size, dst_size);
   assign wide_bytes = psize_bytes(wide_size);

   for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
      localparam logic [1:0] MYSEL = (gi == 0) ? SEL_SRC : SEL_DST;
      dma_ptr_step #(.AW(AW)) u_ptr (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (wr_ok && (wr_sel == MYSEL)),
         .load_val   (wr_data),
         .step_en    (step && inc_v[gi]),
         .step_bytes (psize_bytes(size_v[gi])),
         .addr       (ptr_v[gi])
      );
   end

   dma_cnt_unit #(.CW(CW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_ok && (wr_sel == SEL_CNT)),
      .load_val  (wr_data[CW-1:0]),
      .dec_en    (step),
      .dec_bytes (wide_bytes),
      .cnt       (byte_cnt),
      .last      (cnt_last)
   );

   dma_cfg_check u_chk (
      .src_lo   (ptr_v[0][1:0]),
      .dst_lo   (ptr_v[1][1:0]),
      .cnt_lo   (byte_cnt[1:0]),
      .cnt_zero (byte_cnt == '0),
      .src_size (src_size),
      .dst_size (dst_size),
      .cfg_ok   (cfg_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         tc_q     <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         err_q <= fault || err_held;
         if (launch) begin
            active_q <= 1'b1;
            tc_q     <= 1'b0;
         end else if (step && cnt_last) begin
            active_q <= 1'b0;
            tc_q     <= 1'b1;
         end
      end
   end

   assign src_addr = ptr_v[0];
   assign dst_addr = ptr_v[1];
   assign active   = active_q;
   assign tc       = tc_q;
   assign cfg_err  = err_q;
endmodule

// File: rtl/dma_ptr_unit_chk.sv
module dma_ptr_unit_chk
   import dma_ptr_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [1:0]    dst_size,
   input logic          src_inc,
   input logic          dst_inc,
   input logic          start,
   input logic          xfer_done,
   input logic          err_clr,
   input logic [AW-1:0] src_addr,
   input logic [AW-1:0] dst_addr,
   input logic [CW-1:0] byte_cnt,
   input logic          active,
   input logic          tc,
   input logic          cfg_err
);
   logic [AW-1:0] dst_plus;
   assign dst_plus = dst_addr + {{(AW-3){1'b0}}, psize_bytes(dst_size)};

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err && !err_clr |=> cfg_err);

   assert_start_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err && !err_clr && !active && start |=> !active);

   assert_tc_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc) |-> (byte_cnt == '0) && !active);

   assert_run_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> byte_cnt != '0);

   assert_src_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      active && xfer_done && !src_inc |=> $stable(src_addr));

   assert_dst_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      active && xfer_done && dst_inc |=> dst_addr == $past(dst_plus));

   assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !active && xfer_done && !wr_en |=> $stable(byte_cnt) && $stable(src_addr) && $stable(dst_addr));

   assert_busy_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active && wr_en && !xfer_done |=> $stable(byte_cnt) && $stable(src_addr) && $stable(dst_addr));
endmodule

bind dma_ptr_unit dma_ptr_unit_chk #(.AW(AW), .CW(CW)) u_prop (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .dst_size  (dst_size),
   .src_inc   (src_inc),
   .dst_inc   (dst_inc),
   .start     (start),
   .xfer_done (xfer_done),
   .err_clr   (err_clr),
   .src_addr  (src_addr),
   .dst_addr  (dst_addr),
   .byte_cnt  (byte_cnt),
   .active    (active),
   .tc        (tc),
   .cfg_err   (cfg_err)
);

// File: tb/sim_dma_ptr_unit.sv
`timescale 1ns/1ps
module sim_dma_ptr_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 0, src_inc = 0, dst_inc = 0, start = 0, xfer_done = 0, err_clr = 0;
   logic [1:0] wr_sel = 0, src_size = 0, dst_size = 0;
   logic [31:0] wr_data = 0;
   logic [31:0] src_addr, dst_addr, byte_cnt;
   logic active, tc, cfg_err;

   int total = 0;
   int bad = 0;

   logic [31:0] m_src = 0, m_dst = 0, m_cnt = 0;
   logic m_act = 0, m_tc = 0, m_err = 0;

   always #2.5 clk = ~clk;

   dma_ptr_unit u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .src_size(src_size), .dst_size(dst_size), .src_inc(src_inc), .dst_inc(dst_inc),
      .start(start), .xfer_done(xfer_done), .err_clr(err_clr),
      .src_addr(src_addr), .dst_addr(dst_addr), .byte_cnt(byte_cnt),
      .active(active), .tc(tc), .cfg_err(cfg_err)
   );

   function automatic logic [31:0] sb(input logic [1:0] s);
      case (s)
         2'b00: sb = 4;
         2'b01: sb = 1;
         2'b10: sb = 2;
         default: sb = 0;
      endcase
   endfunction

   function automatic logic good_cfg(input logic [31:0] s, input logic [31:0] d,
                                     input logic [31:0] c, input logic [1:0] ss, input logic [1:0] ds);
      logic [31:0] w;
      if (ss == 2'b11 || ds == 2'b11) return 1'b0;
      w = (sb(ss) > sb(ds)) ? sb(ss) : sb(ds);
      if (c == 0) return 1'b0;
      if ((s % sb(ss)) != 0 || (d % sb(ds)) != 0) return 1'b0;
      return (c % w) == 0;
   endfunction

   task automatic cmp(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
      end
   endtask

   task automatic chk(input string tag);
      cmp(tag, "src_addr", src_addr, m_src);
      cmp(tag, "dst_addr", dst_addr, m_dst);
      cmp(tag, "byte_cnt", byte_cnt, m_cnt);
      cmp(tag, "active", {31'b0, active}, {31'b0, m_act});
      cmp(tag, "tc", {31'b0, tc}, {31'b0, m_tc});
      cmp(tag, "cfg_err", {31'b0, cfg_err}, {31'b0, m_err});
   endtask

   task automatic model;
      logic wr_ok, held, tryst, ok, stp;
      logic [31:0] w;
      wr_ok = wr_en && !m_act;
      held  = m_err && !err_clr;
      tryst = start && !m_act && !held;
      ok    = good_cfg(m_src, m_dst, m_cnt, src_size, dst_size);
      stp   = xfer_done && m_act;
      w     = (sb(src_size) > sb(dst_size)) ? sb(src_size) : sb(dst_size);
      m_err = (tryst && !ok) || held;
      if (tryst && ok) begin
         m_act = 1; m_tc = 0;
      end
      if (wr_ok) begin
         if (wr_sel == 2'b00) m_src = wr_data;
         if (wr_sel == 2'b01) m_dst = wr_data;
         if (wr_sel == 2'b10) m_cnt = wr_data;
      end else if (stp) begin
         if (src_inc) m_src = m_src + sb(src_size);
         if (dst_inc) m_dst = m_dst + sb(dst_size);
         if (m_cnt <= w) begin
            m_cnt = 0; m_act = 0; m_tc = 1;
         end else m_cnt = m_cnt - w;
      end
   endtask

   task automatic cyc(input logic we, input logic [1:0] sel, input logic [31:0] d,
                      input logic st, input logic xd, input logic ec, input string tag);
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_data = d; start = st; xfer_done = xd; err_clr = ec;
      @(posedge clk);
      model();
      #1;
      chk(tag);
   endtask

   task automatic load3(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c, input string tag);
      cyc(1, 2'b00, s, 0, 0, 0, tag);
      cyc(1, 2'b01, d, 0, 0, 0, tag);
      cyc(1, 2'b10, c, 0, 0, 0, tag);
   endtask

   initial begin
      #(5.0 * 150000);
      bad++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 chk("R1 reset state");
      @(negedge clk) rst_n = 1'b1;

      // main run: source 4-byte, destination 2-byte
      src_size = 2'b00; dst_size = 2'b10; src_inc = 1; dst_inc = 1;
      load3(32'h100, 32'h202, 32'd8, "R2 register load");
      cyc(0, 0, 0, 0, 1, 0, "R10 done while idle");
      cyc(0, 0, 0, 1, 0, 0, "R11 start launches");
      cyc(0, 0, 0, 0, 1, 0, "R6 R7 R8 first step");
      cyc(1, 2'b00, 32'h5000, 0, 0, 0, "R2 write while active ignored");
      cyc(0, 0, 0, 1, 0, 0, "R11 start while active ignored");
      cyc(0, 0, 0, 0, 1, 0, "R8 terminal count");
      cyc(1, 2'b11, 32'hffff, 0, 0, 0, "R2 select 11 loads nothing");

      // source held, destination steps by its own byte size
      src_size = 2'b01; dst_size = 2'b00; src_inc = 0; dst_inc = 1;
      load3(32'h33, 32'h400, 32'd8, "R2 reload");
      cyc(0, 0, 0, 1, 0, 0, "R11 start clears tc");
      cyc(0, 0, 0, 0, 1, 0, "R6 fixed source R7 destination size");
      cyc(0, 0, 0, 0, 1, 0, "R8 end of second run");

      // faults
      src_size = 2'b00; dst_size = 2'b00; src_inc = 1;
      load3(32'h102, 32'h400, 32'd8, "R3 setup");
      cyc(0, 0, 0, 1, 0, 0, "R3 misaligned source");
      cyc(1, 2'b00, 32'h100, 0, 0, 0, "R9 fix source");
      cyc(0, 0, 0, 1, 0, 0, "R9 start blocked while fault held");
      cyc(0, 0, 0, 0, 0, 1, "R9 clear");
      dst_size = 2'b11;
      cyc(0, 0, 0, 1, 0, 0, "R3 invalid size code");
      dst_size = 2'b10;
      cyc(1, 2'b10, 32'd6, 0, 0, 1, "R4 setup");
      cyc(0, 0, 0, 1, 0, 0, "R4 count not multiple of wider size");
      cyc(1, 2'b10, 32'd0, 0, 0, 1, "R5 setup");
      cyc(0, 0, 0, 1, 0, 0, "R5 zero count");
      cyc(1, 2'b10, 32'd12, 0, 0, 0, "R9 good count with fault held");
      cyc(0, 0, 0, 1, 0, 1, "R9 clear and start same cycle");
      cyc(0, 0, 0, 0, 1, 0, "R8 step after combined start");
      dst_size = 2'b01;
      cyc(0, 0, 0, 0, 1, 0, "R7 byte destination step");
      cyc(0, 0, 0, 0, 1, 0, "R8 finish");
      cyc(1, 2'b01, 32'h401, 0, 0, 0, "R3 setup");
      cyc(0, 0, 0, 1, 0, 0, "R3 misaligned destination");
      cyc(0, 0, 0, 1, 0, 1, "R9 clear with start on bad set");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int k;
         logic [31:0] d;
         k = $urandom_range(0, 9);
         d = $urandom_range(0, 63);
         if ($urandom_range(0, 3) != 0) d = d & 32'hfffffffc;
         if (!m_act && $urandom_range(0, 7) == 0) begin
            src_size = 2'($urandom_range(0, 3));
            dst_size = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 4) != 0 && src_size == 2'b11) src_size = 2'b00;
            if ($urandom_range(0, 4) != 0 && dst_size == 2'b11) dst_size = 2'b10;
            src_inc = 1'($urandom_range(0, 1));
            dst_inc = 1'($urandom_range(0, 1));
         end
         cyc(k < 3, 2'($urandom_range(0, 3)), d, k == 3 || k == 4,
             k >= 5 && k <= 8, $urandom_range(0, 5) == 0, "R6 R7 R8 R9 random mix");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule